// File: doc/BRIEF.md
# Keyed watchdog timer controller

This block is a watchdog timer whose on/off state is governed by a 5-bit key field rather than a plain enable bit. Two key codes are legal: one lets the time-out counter run, the other freezes it. Any other code written to the field is treated as a fault. It clears the counter and, after a fixed number of cycles, issues a full device reset. It also records the event in a sticky cause flag that only software can clear.

While the counter runs, it advances once per cycle in which the watchdog tick enable is high. It must be cleared by a clear-watchdog strobe or a halt strobe before it wraps. A wrap in normal run mode requests a full device reset. A wrap while the core is in a low-power (sleep or idle) state requests only a partial reset, which covers the program counter and stack pointer. In both cases the time-out status bit is set. The cause flag and the time-out bit are held across the resets the block itself requests. Only the power-on reset input returns them to zero.

Top module: `wdg_keyed`

## Requirements
- R1: After the synchronous power-on reset the key field reads 01010, the cause register reads 0x00, the time-out bit is 0, and neither reset request is asserted.
- R2: While the key field holds 10101 the counter does not advance, so no time-out and no reset request arises however long the tick runs.
- R3: While the key field holds 01010 and low_pwr is 0, the 2^CNT_W-th tick after a counter clear produces a one-cycle full_rst_req pulse and sets the time-out bit. The pulse appears in the cycle after the edge that consumed that tick.
- R4: The same wrap with low_pwr at 1 produces a one-cycle part_rst_req pulse instead, sets the time-out bit, and leaves full_rst_req low.
- R5: A clear-watchdog strobe or a halt strobe zeroes the counter and clears the time-out bit at the same edge.
- R6: A key write of any value other than 01010 or 10101 clears the counter, stores the written value, and asserts full_rst_req exactly SRST_DLY cycles after the write edge, for one cycle.
- R7: Key writes made while such a reset is pending still update the key field but neither cancel the pending reset nor restart its delay.
- R8: Bit 0 of the cause register is set at the edge where the delayed key-fault reset fires, and this set has priority over a software clear in the same cycle. It is cleared only by a cause-register write with bit 0 = 0. Writing 1 has no effect, and neither reset request clears it.
- R9: Bits 7 to 1 of the cause register always read 0 and ignore writes.
- R10: When the key-fault reset fires, the key field returns to 01010 and the counter restarts from zero, so the next time-out follows 2^CNT_W ticks later.
- R11: The counter advances only on cycles where tick is high; cycles with tick low leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| tick | input | 1 | Watchdog count enable, one pulse per count |
| key_we | input | 1 | Write strobe for the key field |
| key_wdata | input | 5 | New key value |
| flag_we | input | 1 | Write strobe for the cause register |
| flag_wdata | input | FLAG_W | Cause register write data (only bit 0 matters, and only as a clear) |
| clr_wdt | input | 1 | Clear-watchdog instruction strobe |
| halt | input | 1 | Halt instruction strobe |
| low_pwr | input | 1 | Core is in sleep or idle mode |
| key_q | output | 5 | Current key field |
| flag_q | output | FLAG_W | Cause register; bit 0 is the key-fault flag |
| timeout | output | 1 | Time-out status bit |
| full_rst_req | output | 1 | Full device reset request pulse |
| part_rst_req | output | 1 | Program counter and stack pointer reset request pulse |

## Verification
The assertions check the following on every cycle:
- The partial reset never coincides with a full reset, and it is always accompanied by the time-out bit.
- A clear or halt strobe leaves the counter at zero and the time-out bit low.
- The counter holds when there is no tick.
- A bad key write arms the delay, and the delay stays armed until it fires.
- Firing restores the enable key.
- The cause flag stays set unless software writes a zero.

Only the bench's scenarios can show the following:
- The exact wrap cycle and the exact reset delay.
- That later key writes neither cancel nor restart a pending fault reset.
- That the set of the flag wins over a clear in the same cycle.
- That the upper cause bits ignore written ones.

// File: rtl/wdg_keyed_pkg.sv
// Package: key codes and key classification shared by the watchdog modules.
// Assumes a 5-bit key field; all other widths are module parameters.
package wdg_keyed_pkg;

    localparam int KEY_W = 5;
    localparam logic [KEY_W-1:0] KEY_RUN  = 5'b01010;
    localparam logic [KEY_W-1:0] KEY_STOP = 5'b10101;

    typedef enum logic [1:0] {
        KM_RUN  = 2'd0,
        KM_STOP = 2'd1,
        KM_BAD  = 2'd2
    } key_mode_e;

    // Classify a key value into run, stop or fault.
    function automatic key_mode_e key_decode(input logic [KEY_W-1:0] k);
        if (k == KEY_RUN)       return KM_RUN;
        else if (k == KEY_STOP) return KM_STOP;
        else                    return KM_BAD;
    endfunction

endpackage

// File: rtl/wdg_tmr_cnt.sv
// Time-out counter. Counts run&&tick cycles and flags the wrap of the
// 2^CNT_W-th count. Assumes clr has priority over counting, so no wrap is
// reported in a clear cycle.
module wdg_tmr_cnt #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic tick,
    output logic ovf
);
    localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt;

    // Wrap strobe: last count value consumed by a live tick.
    assign ovf = run && tick && !clr && (cnt == CNT_LAST);

    // Counter register: cleared by reset or clr, advanced by live ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)     cnt <= '0;
        else if (run && tick)  cnt <= cnt + CNT_W'(1);
    end

    a_r5_clr_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
    a_r11_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(run && tick)) |=> $stable(cnt));

endmodule

// File: rtl/wdg_key_ctrl.sv
// Key field and fault-reset delay. Holds the key, decodes it, and arms a
// delay of SRST_DLY cycles on a bad key write. The delay is not restarted by
// later writes. When it fires, the key returns to the enable code.
// Assumes SRST_DLY >= 1.
module wdg_key_ctrl
    import wdg_keyed_pkg::*;
#(
    parameter int SRST_DLY = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_we,
    input  logic [KEY_W-1:0] key_wdata,
    output logic [KEY_W-1:0] key_q,
    output logic             run,
    output logic             bad_wr,
    output logic             fire
);
    localparam int DLY_W = $clog2(SRST_DLY + 1);
    localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(SRST_DLY - 1);

    logic             pending;
    logic [DLY_W-1:0] dly;

    // Decode of the incoming write and of the held key.
    assign bad_wr = key_we && (key_decode(key_wdata) == KM_BAD);
    assign run    = (key_decode(key_q) == KM_RUN);
    assign fire   = pending && (dly == DLY_LAST);

    // Key register: power-on and fire restore the enable code; writes land otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      key_q <= KEY_RUN;
        else if (fire)   key_q <= KEY_RUN;
        else if (key_we) key_q <= key_wdata;
    end

    // Delay tracker: arms once on a bad write, counts every cycle, drops on fire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            dly     <= '0;
        end else if (fire) begin
            pending <= 1'b0;
            dly     <= '0;
        end else if (pending) begin
            dly     <= dly + DLY_W'(1);
        end else if (bad_wr) begin
            pending <= 1'b1;
            dly     <= '0;
        end
    end

    a_r6_bad_write_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_wr && !pending) |=> pending);
    a_r7_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !fire) |=> pending);
    a_r10_fire_restores: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (key_q == KEY_RUN && !pending));

endmodule

// File: rtl/wdg_cause_flag.sv
// Sticky reset-cause register. Bit 0 is set by hardware and cleared only by a
// software write of 0; a write of 1 does nothing. The upper bits are tied to 0.
// Assumes REG_W >= 1.
module wdg_cause_flag #(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set,
    input  logic             we,
    input  logic             clr_bit,
    output logic [REG_W-1:0] flag_q
);
    logic cause;

    // Sticky bit: hardware set wins over a software clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)             cause <= 1'b0;
        else if (set)           cause <= 1'b1;
        else if (we && !clr_bit) cause <= 1'b0;
    end

    // Register image: bit 0 live, the rest read as zero.
    generate
        for (genvar i = 0; i < REG_W; i++) begin : g_bit
            if (i == 0) begin : g_live
                assign flag_q[i] = cause;
            end else begin : g_tied
                assign flag_q[i] = 1'b0;
            end
        end
    endgenerate

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cause && !(we && !clr_bit)) |=> cause);
    a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> cause);

endmodule

// File: rtl/wdg_keyed.sv
// Top of the keyed watchdog. Joins the key control, the time-out counter and
// the cause register, and registers the reset requests and the time-out bit.
// Assumes rst_n is the power-on reset only: the requests this block issues do
// not come back to rst_n.
module wdg_keyed
    import wdg_keyed_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int SRST_DLY = 16,
    parameter int FLAG_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              key_we,
    input  logic [KEY_W-1:0]  key_wdata,
    input  logic              flag_we,
    input  logic [FLAG_W-1:0] flag_wdata,
    input  logic              clr_wdt,
    input  logic              halt,
    input  logic              low_pwr,
    output logic [KEY_W-1:0]  key_q,
    output logic [FLAG_W-1:0] flag_q,
    output logic              timeout,
    output logic              full_rst_req,
    output logic              part_rst_req
);
    logic run, bad_wr, fire, ovf, cnt_clr;
    logic unused_flag_hi;

    // Only bit 0 of a cause write has meaning.
    assign unused_flag_hi = ^flag_wdata;
    // Counter clear sources: software clear, halt, bad key write, fault fire.
    assign cnt_clr = clr_wdt || halt || bad_wr || fire;

    wdg_key_ctrl #(.SRST_DLY(SRST_DLY)) u_key (
        .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_wdata(key_wdata),
        .key_q(key_q), .run(run), .bad_wr(bad_wr), .fire(fire)
    );

    wdg_tmr_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .run(run), .tick(tick),
        .ovf(ovf)
    );

    wdg_cause_flag #(.REG_W(FLAG_W)) u_flag (
        .clk(clk), .rst_n(rst_n), .set(fire), .we(flag_we),
        .clr_bit(flag_wdata[0]), .flag_q(flag_q)
    );

    // Reset requests: a fault fire or a run-mode wrap gives full; a low-power wrap gives partial.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_rst_req <= 1'b0;
            part_rst_req <= 1'b0;
        end else begin
            full_rst_req <= fire || (ovf && !low_pwr);
            part_rst_req <= ovf && low_pwr;
        end
    end

    // Time-out status: set on wrap, cleared by clear or halt strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)                timeout <= 1'b0;
        else if (ovf)              timeout <= 1'b1;
        else if (clr_wdt || halt)  timeout <= 1'b0;
    end

    a_r4_part_not_full: assert property (@(posedge clk) disable iff (!rst_n)
        part_rst_req |-> !full_rst_req);
    a_r4_part_has_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        part_rst_req |-> timeout);
    a_r5_clear_drops_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wdt || halt) |=> !timeout);
    a_r2_stop_no_part: assert property (@(posedge clk) disable iff (!rst_n)
        (key_q == KEY_STOP) |=> !part_rst_req);

endmodule

// File: tb/wdg_keyed_tb.sv
module wdg_keyed_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 4;
    localparam int SRST_DLY = 5;
    localparam int WRAP = 1 << CNT_W;

    localparam logic [15:0] M_FULL = 16'h8000;
    localparam logic [15:0] M_PART = 16'h4000;
    localparam logic [15:0] M_TO   = 16'h2000;
    localparam logic [15:0] M_FLAG = 16'h1FE0;
    localparam logic [15:0] M_KEY  = 16'h001F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1;
    logic key_we = 1'b0;
    logic [4:0] key_wdata = 5'b0;
    logic flag_we = 1'b0;
    logic [7:0] flag_wdata = 8'h0;
    logic clr_wdt = 1'b0;
    logic halt = 1'b0;
    logic low_pwr = 1'b0;
    logic [4:0] key_q;
    logic [7:0] flag_q;
    logic timeout, full_rst_req, part_rst_req;

    wdg_keyed #(.CNT_W(CNT_W), .SRST_DLY(SRST_DLY), .FLAG_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .key_we(key_we),
        .key_wdata(key_wdata), .flag_we(flag_we), .flag_wdata(flag_wdata),
        .clr_wdt(clr_wdt), .halt(halt), .low_pwr(low_pwr), .key_q(key_q),
        .flag_q(flag_q), .timeout(timeout), .full_rst_req(full_rst_req),
        .part_rst_req(part_rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int          cyc;
        string       req;
        logic [15:0] val;
        logic [15:0] mask;
    } exp_t;

    exp_t sb_q[$];
    exp_t mon_e;
    int cyc = 0;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] pack(input logic f, input logic p,
        input logic t, input logic [7:0] fl, input logic [4:0] k);
        return {f, p, t, fl, k};
    endfunction

    // Driver side: insert an expectation for cycle cyc+d, kept in cycle order.
    task automatic expect_at(input int d, input string r, input logic [15:0] v,
                             input logic [15:0] m);
        exp_t e;
        int pos;
        e.cyc = cyc + d; e.req = r; e.val = v; e.mask = m;
        pos = sb_q.size();
        for (int i = 0; i < sb_q.size(); i++) begin
            if (sb_q[i].cyc > e.cyc) begin pos = i; break; end
        end
        sb_q.insert(pos, e);
    endtask

    // Monitor side: pop due expectations and compare with the outputs.
    always @(negedge clk) begin
        if (!done) begin
            while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
                logic [15:0] obs;
                mon_e = sb_q.pop_front();
                obs = pack(full_rst_req, part_rst_req, timeout, flag_q, key_q);
                total++;
                if (mon_e.cyc != cyc || ((obs ^ mon_e.val) & mon_e.mask) != 16'h0) begin
                    bad++;
                    $display("FAIL %s cyc=%0d actual=%h expected=%h mask=%h",
                             mon_e.req, cyc, obs & mon_e.mask,
                             mon_e.val & mon_e.mask, mon_e.mask);
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic do_clr();
        clr_wdt = 1'b1; step(1); clr_wdt = 1'b0;
    endtask

    task automatic do_halt();
        halt = 1'b1; step(1); halt = 1'b0;
    endtask

    task automatic wr_key(input logic [4:0] v);
        key_we = 1'b1; key_wdata = v; step(1); key_we = 1'b0;
    endtask

    task automatic wr_flag(input logic [7:0] v);
        flag_we = 1'b1; flag_wdata = v; step(1); flag_we = 1'b0;
    endtask

    initial begin
        step(3);
        // R1: reset state
        expect_at(0, "R1", pack(0, 0, 0, 8'h00, 5'b01010), 16'hFFFF);
        rst_n = 1'b1;
        step(2);

        // R3: run-mode wrap
        do_clr();
        expect_at(WRAP-1, "R3", pack(0, 0, 0, 8'h00, 5'b0), M_FULL | M_TO);
        expect_at(WRAP,   "R3", pack(1, 0, 1, 8'h00, 5'b0), M_FULL | M_PART | M_TO);
        expect_at(WRAP+1, "R3", pack(0, 0, 1, 8'h00, 5'b0), M_FULL | M_TO);
        step(WRAP + 3);

        // R5: halt clears counter and time-out
        do_clr();
        step(10);
        do_halt();
        expect_at(0, "R5", pack(0, 0, 0, 8'h00, 5'b0), M_TO);
        expect_at(5, "R5", pack(0, 0, 0, 8'h00, 5'b0), M_FULL);
        expect_at(WRAP, "R5", pack(1, 0, 1, 8'h00, 5'b0), M_FULL | M_TO);
        step(WRAP + 2);

        // R4: low-power wrap gives only the partial reset
        low_pwr = 1'b1;
        do_clr();
        expect_at(0, "R5", pack(0, 0, 0, 8'h00, 5'b0), M_TO);
        expect_at(WRAP,   "R4", pack(0, 1, 1, 8'h00, 5'b0), M_FULL | M_PART | M_TO);
        expect_at(WRAP+1, "R4", pack(0, 0, 1, 8'h00, 5'b0), M_FULL | M_PART);
        step(WRAP + 2);
        low_pwr = 1'b0;

        // R11: counting only on tick cycles
        tick = 1'b0;
        do_clr();
        expect_at(WRAP+19, "R11", pack(0, 0, 0, 8'h00, 5'b0), M_FULL);
        expect_at(WRAP+20, "R11", pack(1, 0, 1, 8'h00, 5'b0), M_FULL | M_TO);
        step(20);
        tick = 1'b1;
        step(WRAP + 2);

        // R2: stop key freezes the watchdog
        do_clr();
        wr_key(5'b10101);
        expect_at(0,  "R2", pack(0, 0, 0, 8'h00, 5'b10101), M_KEY | M_TO);
        expect_at(20, "R2", pack(0, 0, 0, 8'h00, 5'b10101), M_FULL | M_PART | M_TO | M_KEY);
        expect_at(40, "R2", pack(0, 0, 0, 8'h00, 5'b10101), M_FULL | M_PART | M_TO | M_KEY);
        step(41);
        wr_key(5'b01010);
        expect_at(0, "R2", pack(0, 0, 0, 8'h00, 5'b01010), M_KEY);
        do_clr();

        // R6 / R10: bad key write, delayed fault reset, restart after it
        wr_key(5'b00111);
        expect_at(0, "R6", pack(0, 0, 0, 8'h00, 5'b00111), M_FULL | M_KEY | M_FLAG);
        expect_at(SRST_DLY-1, "R6", pack(0, 0, 0, 8'h00, 5'b00111), M_FULL | M_KEY | M_FLAG);
        expect_at(SRST_DLY, "R6", pack(1, 0, 0, 8'h01, 5'b01010), M_FULL | M_TO | M_FLAG | M_KEY);
        expect_at(SRST_DLY+1, "R6", pack(0, 0, 0, 8'h01, 5'b01010), M_FULL | M_FLAG);
        expect_at(SRST_DLY+WRAP-1, "R10", pack(0, 0, 0, 8'h01, 5'b0), M_FULL | M_TO);
        expect_at(SRST_DLY+WRAP, "R10", pack(1, 0, 1, 8'h01, 5'b0), M_FULL | M_TO | M_FLAG);
        step(SRST_DLY + WRAP + 2);

        // R8 / R9: cause register write rules; flag survived both full resets
        wr_flag(8'h01);
        expect_at(0, "R8", pack(0, 0, 0, 8'h01, 5'b0), M_FLAG);
        wr_flag(8'hFF);
        expect_at(0, "R9", pack(0, 0, 0, 8'h01, 5'b0), M_FLAG);
        wr_flag(8'hFE);
        expect_at(0, "R8", pack(0, 0, 0, 8'h00, 5'b0), M_FLAG);
        wr_flag(8'hFF);
        expect_at(0, "R9", pack(0, 0, 0, 8'h00, 5'b0), M_FLAG);

        // R7: writes during the delay neither cancel nor restart it; R8 set wins
        do_clr();
        wr_key(5'b11111);
        expect_at(2, "R7", pack(0, 0, 0, 8'h00, 5'b10101), M_FULL | M_KEY);
        expect_at(3, "R7", pack(0, 0, 0, 8'h00, 5'b00000), M_FULL | M_KEY);
        expect_at(4, "R7", pack(0, 0, 0, 8'h00, 5'b0), M_FULL | M_FLAG);
        expect_at(SRST_DLY, "R7", pack(1, 0, 0, 8'h01, 5'b01010), M_FULL | M_KEY);
        expect_at(SRST_DLY, "R8", pack(1, 0, 0, 8'h01, 5'b01010), M_FLAG);
        expect_at(SRST_DLY+1, "R8", pack(0, 0, 0, 8'h01, 5'b0), M_FLAG);
        expect_at(SRST_DLY+3, "R7", pack(0, 0, 0, 8'h01, 5'b0), M_FULL);
        step(1);
        wr_key(5'b10101);
        wr_key(5'b00000);
        step(1);
        wr_flag(8'h00);
        step(6);

        step(3);
        if (sb_q.size() != 0) begin
            bad++; total++;
            $display("FAIL scoreboard: %0d expectations left, expected 0", sb_q.size());
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog: bench hung at cyc=%0d, expected completion", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule